// File: doc/BRIEF.md
# PCI Bus Master Transaction Sequencer

This block is the initiator side of a 32-bit PCI interface. A local DMA engine hands it one request at a time: a start address, a direction and a DWord count. A read request becomes one burst Memory Read transaction with as many data phases as the count asks for. A write request becomes a chain of single-data-phase Memory Write transactions at consecutive DWord addresses, all inside one bus tenure. The block raises the bus request, waits for the grant and an idle bus, and then drives FRAME, IRDY, C/BE, AD and PAR. It samples DEVSEL and TRDY from the target.

Read data goes out to the engine with a one-cycle valid strobe. Write data and a per-DWord byte mask come from the head of the engine's queue, and the block pulses a take strobe when each DWord has been transferred. An option input chooses when the bus request is dropped: early, in the same clock as the last FRAME assertion, or late, after the final data phase. If no target claims the transaction within four clocks, the block ends it with a master abort and reports an error on completion.

Top module: `pci_master_seq`

## Requirements
- R1: After reset, pciReqN, pciFrameN and pciIrdyN are high, pciAdOe is low and reqReady is high.
- R2: A read request of N DWords produces one transaction. Its address phase carries the start address on AD and command 0110 on C/BE. In every data phase AD is released and C/BE is 0000. The N words come out on rdData with rdValid in bus order. FRAME is deasserted in the clock where IRDY is asserted for the final data phase, so exactly N-1 transfers complete with FRAME low.
- R3: A write request of N DWords produces N transactions. Each one has command 0111, an address equal to the start address plus 4 times its index, and a single data phase with FRAME already high. In that data phase AD carries wrData and C/BE carries the bitwise inverse of the active-high mask wrBe.
- R4: Between consecutive write transactions, FRAME and IRDY are both high for at least one clock before FRAME falls again, and pciReqN stays low at every address phase except possibly the last.
- R5: With keepBusReq low, pciReqN rises in the same clock in which FRAME falls for the last transaction of the request.
- R6: With keepBusReq high, pciReqN stays low through every address phase and rises in the clock after the last data phase completes.
- R7: An address phase starts only after an edge where pciGntN is low and both busFrameN and busIrdyN are high.
- R8: IRDY is asserted in the clock right after each address phase. While IRDY is asserted, DEVSEL is asserted and TRDY is not, IRDY stays asserted and a driven AD value does not change.
- R9: In the clock after every clock in which the block drives AD, pciParOe is high and pciParOut equals the even parity over the previous AD and C/BE values.
- R10: One clock after each read rdValid, parErr pulses if and only if pciParIn differs from the even parity of that word with C/BE 0000.
- R11: If DEVSEL is not sampled low on any of the four edges that follow the IRDY assertion, FRAME is high at the next clock, IRDY goes high one clock later, and the request ends with done and doneErr together. DEVSEL first seen on the fourth edge still completes normally.
- R12: reqReady is high only while the block is idle. Each request ends with exactly one done pulse, and doneErr is low unless the request was aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| keepBusReq | input | 1 | 1: hold the request until the last data phase ends |
| reqValid | input | 1 | Local request present |
| reqWrite | input | 1 | 1 = write chain, 0 = read burst |
| reqAddr | input | 32 | DWord-aligned start address |
| reqCount | input | CountW | DWords to move, at least 1 |
| reqReady | output | 1 | Idle, a request is accepted this clock |
| wrData | input | 32 | Head of the local write queue |
| wrBe | input | 4 | Active-high byte mask for wrData |
| wrTake | output | 1 | Head DWord was transferred |
| rdData | output | 32 | Read word |
| rdValid | output | 1 | rdData valid |
| parErr | output | 1 | Read parity mismatch |
| done | output | 1 | Request finished |
| doneErr | output | 1 | Request ended by master abort |
| pciReqN | output | 1 | Bus request |
| pciGntN | input | 1 | Bus grant |
| pciFrameN | output | 1 | FRAME driven by this master |
| pciIrdyN | output | 1 | IRDY driven by this master |
| busFrameN | input | 1 | FRAME as seen on the bus |
| busIrdyN | input | 1 | IRDY as seen on the bus |
| pciDevselN | input | 1 | Target claim |
| pciTrdyN | input | 1 | Target ready |
| pciAdOut | output | 32 | AD output value |
| pciAdOe | output | 1 | AD output enable |
| pciAdIn | input | 32 | AD as seen on the bus |
| pciCbeN | output | 4 | Command / byte enables |
| pciParOut | output | 1 | Parity output |
| pciParOe | output | 1 | Parity output enable |
| pciParIn | input | 1 | Parity driven by the target |

## Verification
Reads are run as a three-word burst with one target wait state, as a one-word read whose DEVSEL comes on the last permitted edge, and as a two-word burst with one corrupted parity bit. Between them they separate burst FRAME handling, the abort boundary and the parity checker. Writes are run as a three-DWord chain with mixed byte masks and wait states, once with the request released early and once with it held. This shows the separate transactions, the address stepping, the idle gap and both request-release rules. A grant that arrives late while another master holds FRAME shows that the start waits for an idle bus. A transaction no target claims shows the master-abort order.

// File: rtl/pci_mseq_pkg.sv
package pci_mseq_pkg;
  localparam int BusW  = 32;
  localparam int LaneN = BusW / 8;

  localparam logic [3:0] CmdMemRead  = 4'b0110;
  localparam logic [3:0] CmdMemWrite = 4'b0111;

  typedef enum logic [2:0] {
    StIdle,
    StArb,
    StAddr,
    StData,
    StAbort
  } seqState_t;

  // control-to-datapath strobes, all valid for the current clock edge
  typedef struct packed {
    logic accept;    // latch the request address
    logic loadAddr;  // address phase begins
    logic loadData;  // first data phase begins
    logic isWrite;   // current request direction
    logic xfer;      // data phase completes at this edge
    logic dropBus;   // abort tail, stop driving AD
  } seqStrobe_t;
endpackage

// File: rtl/pci_mseq_datapath.sv
module pci_mseq_datapath
  import pci_mseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [BusW-1:0]  reqAddr,
  input  logic [BusW-1:0]  wrData,
  input  logic [LaneN-1:0] wrBe,
  input  logic [BusW-1:0]  adIn,
  input  logic             parIn,
  output logic [BusW-1:0]  adOut,
  output logic             adOe,
  output logic [LaneN-1:0] cbeN,
  output logic             parOut,
  output logic             parOe,
  output logic [BusW-1:0]  rdData,
  output logic             parErr
);
  localparam logic [BusW-1:0] DwordStep = BusW'(LaneN);

  logic [BusW-1:0] addrR;
  logic            chkPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR <= '0;
      adOut <= '0;
      adOe  <= 1'b0;
      cbeN  <= '1;
    end else begin
      if (strb.accept) addrR <= reqAddr;
      if (strb.loadAddr) begin
        adOut <= addrR;
        cbeN  <= strb.isWrite ? CmdMemWrite : CmdMemRead;
        adOe  <= 1'b1;
      end else if (strb.loadData) begin
        if (strb.isWrite) begin
          adOut <= wrData;
          cbeN  <= ~wrBe;
          adOe  <= 1'b1;
        end else begin
          cbeN  <= '0;
          adOe  <= 1'b0;
        end
      end else if (strb.xfer && strb.isWrite) begin
        addrR <= addrR + DwordStep;
        adOe  <= 1'b0;
      end else if (strb.dropBus) begin
        adOe  <= 1'b0;
      end
    end
  end

  // parity trails the AD/C/BE it covers by one clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parOut <= 1'b0;
      parOe  <= 1'b0;
    end else begin
      parOut <= ^{adOut, cbeN};
      parOe  <= adOe;
    end
  end

  // read data capture and target parity check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      chkPend <= 1'b0;
      parErr  <= 1'b0;
    end else begin
      parErr  <= chkPend && (parIn != ^rdData);
      chkPend <= 1'b0;
      if (strb.xfer && !strb.isWrite) begin
        rdData  <= adIn;
        chkPend <= 1'b1;
      end
    end
  end

  p_par_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> (parOut == ^{$past(adOut), $past(cbeN)}));
endmodule

// File: rtl/pci_mseq_ctrl.sv
module pci_mseq_ctrl
  import pci_mseq_pkg::*;
#(
  parameter int CountW     = 8,
  parameter int DevselWait = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keepBusReq,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [CountW-1:0] reqCount,
  input  logic              gntN,
  input  logic              busFrameN,
  input  logic              busIrdyN,
  input  logic              devselN,
  input  logic              trdyN,
  output logic              reqReady,
  output logic              busReqN,
  output logic              frameN,
  output logic              irdyN,
  output logic              wrTake,
  output logic              rdValid,
  output logic              done,
  output logic              doneErr,
  output seqStrobe_t        strb
);
  localparam int WaitW = (DevselWait > 1) ? $clog2(DevselWait) : 1;
  localparam logic [WaitW-1:0] WaitLast = WaitW'(DevselWait - 1);
  localparam logic [CountW-1:0] CntOne = CountW'(1);
  localparam logic [CountW-1:0] CntTwo = CountW'(2);

  seqState_t         state;
  logic [CountW-1:0] remaining;
  logic              isWrite;
  logic [WaitW-1:0]  devWait;
  logic              devSeen;

  logic accept, startOk, xfer, abortNow, lastTxn, lastPhase;

  always_comb begin
    accept    = (state == StIdle) && reqValid;
    startOk   = (state == StArb) && !gntN && busFrameN && busIrdyN;
    xfer      = (state == StData) && !trdyN;
    abortNow  = (state == StData) && trdyN && !devSeen && devselN && (devWait == WaitLast);
    lastTxn   = !isWrite || (remaining == CntOne);
    lastPhase = isWrite || (remaining == CntOne);
    reqReady  = (state == StIdle);
    strb.accept   = accept;
    strb.loadAddr = startOk;
    strb.loadData = (state == StAddr);
    strb.isWrite  = isWrite;
    strb.xfer     = xfer;
    strb.dropBus  = (state == StAbort);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= StIdle;
      remaining <= '0;
      isWrite   <= 1'b0;
      devWait   <= '0;
      devSeen   <= 1'b0;
      busReqN   <= 1'b1;
      frameN    <= 1'b1;
      irdyN     <= 1'b1;
      wrTake    <= 1'b0;
      rdValid   <= 1'b0;
      done      <= 1'b0;
      doneErr   <= 1'b0;
    end else begin
      wrTake  <= 1'b0;
      rdValid <= 1'b0;
      done    <= 1'b0;
      doneErr <= 1'b0;
      unique case (state)
        StIdle: if (accept) begin
          remaining <= reqCount;
          isWrite   <= reqWrite;
          busReqN   <= 1'b0;
          state     <= StArb;
        end
        StArb: if (startOk) begin
          frameN <= 1'b0;
          if (lastTxn && !keepBusReq) busReqN <= 1'b1;
          state  <= StAddr;
        end
        StAddr: begin
          irdyN   <= 1'b0;
          if (lastPhase) frameN <= 1'b1;
          devWait <= '0;
          devSeen <= 1'b0;
          state   <= StData;
        end
        StData: begin
          if (!devselN) devSeen <= 1'b1;
          if (xfer) begin
            remaining <= remaining - CntOne;
            wrTake    <= isWrite;
            rdValid   <= !isWrite;
            if (!isWrite && remaining == CntTwo) frameN <= 1'b1;
            if (lastPhase) begin
              irdyN <= 1'b1;
              if (remaining == CntOne) begin
                done    <= 1'b1;
                busReqN <= 1'b1;
                state   <= StIdle;
              end else begin
                state   <= StArb;
              end
            end
          end else if (abortNow) begin
            frameN <= 1'b1;
            state  <= StAbort;
          end else if (!devSeen && devselN) begin
            devWait <= devWait + WaitW'(1);
          end
        end
        StAbort: begin
          irdyN     <= 1'b1;
          done      <= 1'b1;
          doneErr   <= 1'b1;
          busReqN   <= 1'b1;
          remaining <= '0;
          state     <= StIdle;
        end
        default: state <= StIdle;
      endcase
    end
  end

  p_irdy_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == StData && trdyN && !abortNow) |=> !irdyN);
  p_req_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(frameN) && lastTxn && !keepBusReq) |-> busReqN);
  p_frame_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameN) |-> $past(irdyN));
  p_abort_order_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == StAbort) |-> (frameN && !irdyN));
  p_single_end_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdValid && done && doneErr, wrTake && doneErr}));
endmodule

// File: rtl/pci_master_seq.sv
module pci_master_seq
  import pci_mseq_pkg::*;
#(
  parameter int CountW     = 8,
  parameter int DevselWait = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keepBusReq,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [31:0]       reqAddr,
  input  logic [CountW-1:0] reqCount,
  output logic              reqReady,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrBe,
  output logic              wrTake,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              parErr,
  output logic              done,
  output logic              doneErr,
  output logic              pciReqN,
  input  logic              pciGntN,
  output logic              pciFrameN,
  output logic              pciIrdyN,
  input  logic              busFrameN,
  input  logic              busIrdyN,
  input  logic              pciDevselN,
  input  logic              pciTrdyN,
  output logic [31:0]       pciAdOut,
  output logic              pciAdOe,
  input  logic [31:0]       pciAdIn,
  output logic [3:0]        pciCbeN,
  output logic              pciParOut,
  output logic              pciParOe,
  input  logic              pciParIn
);
  seqStrobe_t strb;

  pci_mseq_ctrl #(.CountW(CountW), .DevselWait(DevselWait)) u_ctrl (
    .clk(clk), .rstN(rstN), .keepBusReq(keepBusReq),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqCount(reqCount),
    .gntN(pciGntN), .busFrameN(busFrameN), .busIrdyN(busIrdyN),
    .devselN(pciDevselN), .trdyN(pciTrdyN),
    .reqReady(reqReady), .busReqN(pciReqN), .frameN(pciFrameN), .irdyN(pciIrdyN),
    .wrTake(wrTake), .rdValid(rdValid), .done(done), .doneErr(doneErr),
    .strb(strb)
  );

  pci_mseq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .wrData(wrData), .wrBe(wrBe),
    .adIn(pciAdIn), .parIn(pciParIn),
    .adOut(pciAdOut), .adOe(pciAdOe), .cbeN(pciCbeN),
    .parOut(pciParOut), .parOe(pciParOe),
    .rdData(rdData), .parErr(parErr)
  );

  p_ad_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pciIrdyN && pciTrdyN && !pciDevselN && pciAdOe) |=> (pciAdOe && $stable(pciAdOut)));
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pciFrameN) |-> ($past(busFrameN) && $past(busIrdyN) && !$past(pciGntN)));
endmodule

// File: tb/pci_master_seq_bench.sv
module pci_master_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        keepBusReq = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0]  reqCount = '0;
  logic        reqReady, wrTake, rdValid, parErr, done, doneErr;
  logic [31:0] wrData, rdData, pciAdOut;
  logic [3:0]  wrBe, pciCbeN;
  logic        pciReqN, pciFrameN, pciIrdyN, pciAdOe, pciParOut, pciParOe;
  logic        pciGntN = 1'b0, otherFrameN = 1'b1, otherIrdyN = 1'b1;
  logic        devselN = 1'b1, trdyN = 1'b1, parIn = 1'b0;
  logic [31:0] adIn = '0;
  logic        busFrameN, busIrdyN;
  assign busFrameN = pciFrameN & otherFrameN;
  assign busIrdyN  = pciIrdyN & otherIrdyN;

  logic [31:0] wdata [4];
  logic [3:0]  wbe   [4];
  int wrIdx = 0;
  assign wrData = wdata[wrIdx % 4];
  assign wrBe   = wbe[wrIdx % 4];

  pci_master_seq u_pci_master_seq (
    .clk(clk), .rstN(rstN), .keepBusReq(keepBusReq),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqCount(reqCount),
    .reqReady(reqReady), .wrData(wrData), .wrBe(wrBe), .wrTake(wrTake),
    .rdData(rdData), .rdValid(rdValid), .parErr(parErr), .done(done), .doneErr(doneErr),
    .pciReqN(pciReqN), .pciGntN(pciGntN), .pciFrameN(pciFrameN), .pciIrdyN(pciIrdyN),
    .busFrameN(busFrameN), .busIrdyN(busIrdyN), .pciDevselN(devselN), .pciTrdyN(trdyN),
    .pciAdOut(pciAdOut), .pciAdOe(pciAdOe), .pciAdIn(adIn), .pciCbeN(pciCbeN),
    .pciParOut(pciParOut), .pciParOe(pciParOe), .pciParIn(parIn)
  );

  int errors = 0, checks = 0;
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rdPat(input int i);
    return 32'hA5C3_0000 + 32'(i) * 32'h0011_1113;
  endfunction

  // target configuration
  int devLat = 1, waitSt = 0, badIdx = -1;
  // monitor log
  int ncyc = 0, nAddr, nRd, nWr, nXfer, xferFrame, nPar, parBad, holdBad, irdyBad, cbeBad;
  int nDone, nErr, nParErr, reqRiseCyc, frameRiseCyc, irdyRiseCyc, lastXferCyc;
  logic [31:0] aAd [8];
  logic [3:0]  aCbe [8];
  logic        aReq [8];
  logic        aGap [8];
  int          aCyc [8];
  logic [31:0] rdLog [8];
  logic [31:0] wrAd [8];
  logic [3:0]  wrCbe [8];
  logic pFrame = 1, pIrdy = 1, pReq = 1, pAdOe = 0, pAddrPh = 0;
  logic [31:0] pAd = '0;
  logic [3:0]  pCbe = '1;
  bit tOn = 0;
  int age = 0, wcnt = 0, tIdx = 0;

  task automatic clearLog();
    nAddr = 0; nRd = 0; nWr = 0; nXfer = 0; xferFrame = 0; nPar = 0; parBad = 0;
    holdBad = 0; irdyBad = 0; cbeBad = 0; nDone = 0; nErr = 0; nParErr = 0;
    reqRiseCyc = -1; frameRiseCyc = -1; irdyRiseCyc = -1; lastXferCyc = -1; wrIdx = 0;
  endtask

  always @(negedge clk) begin
    bit xferd, addrNow;
    ncyc++;
    xferd   = rstN && !pIrdy && !trdyN;
    addrNow = !pciFrameN && pFrame;
    if (xferd) begin
      if (!pFrame) xferFrame++;
      nXfer++;
      lastXferCyc = ncyc;
      if (pAdOe) begin
        if (nWr < 8) begin wrAd[nWr] = pAd; wrCbe[nWr] = pCbe; end
        nWr++;
      end
    end
    if (addrNow && nAddr < 8) begin
      aAd[nAddr] = pciAdOut; aCbe[nAddr] = pciCbeN; aReq[nAddr] = pciReqN;
      aGap[nAddr] = pIrdy; aCyc[nAddr] = ncyc; nAddr++;
    end
    if (pAddrPh && pciIrdyN) irdyBad++;
    if (!pIrdy && trdyN && !devselN && !(!pciIrdyN && (!pAdOe || pciAdOut == pAd))) holdBad++;
    if (!pciIrdyN && !pciAdOe && pciCbeN != 4'b0000) cbeBad++;
    if (pciParOe) begin
      nPar++;
      if (pciParOut != ^{pAd, pCbe}) parBad++;
    end
    if (pAdOe && !pciParOe) parBad++;
    if (rdValid) begin if (nRd < 8) rdLog[nRd] = rdData; nRd++; end
    if (parErr) nParErr++;
    if (done) nDone++;
    if (doneErr) nErr++;
    if (wrTake) wrIdx++;
    if (pciReqN && !pReq) reqRiseCyc = ncyc;
    if (pciFrameN && !pFrame) frameRiseCyc = ncyc;
    if (pciIrdyN && !pIrdy) irdyRiseCyc = ncyc;
    // simple target model
    if (xferd && tOn) begin
      parIn = (^adIn) ^ (tIdx == badIdx);
      tIdx++;
    end
    if (addrNow) begin
      tOn = 1; age = 0; wcnt = 0; tIdx = 0; devselN = 1; trdyN = 1;
    end else if (tOn) begin
      if (pciFrameN && pciIrdyN) begin
        tOn = 0; devselN = 1; trdyN = 1;
      end else begin
        age++;
        if (xferd) wcnt = 0;
        else if (!devselN) wcnt++;
        devselN = !(age >= devLat);
        trdyN   = !(!devselN && wcnt >= waitSt);
      end
    end
    adIn = rdPat(tIdx);
    pFrame = pciFrameN; pIrdy = pciIrdyN; pReq = pciReqN; pAdOe = pciAdOe;
    pAd = pciAdOut; pCbe = pciCbeN; pAddrPh = addrNow;
  end

  task automatic stepc();
    @(negedge clk); #1;
  endtask

  task automatic issue(input bit wr, input logic [31:0] addr, input int cnt);
    reqWrite = wr; reqAddr = addr; reqCount = 8'(cnt); reqValid = 1'b1;
    stepc();
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (nDone == 0 && n < 300) begin stepc(); n++; end
    check(nDone != 0, req, 0, 1);
    repeat (3) stepc();
  endtask

  task automatic testReset();
    check(pciReqN && pciFrameN && pciIrdyN, "R1 bus controls idle", {pciReqN, pciFrameN, pciIrdyN}, 3'b111);
    check(!pciAdOe && reqReady, "R1 AD released, ready", {pciAdOe, reqReady}, 2'b01);
  endtask

  task automatic testReadBurst();
    clearLog(); devLat = 2; waitSt = 1; badIdx = -1; keepBusReq = 0;
    issue(0, 32'h0000_4000, 3);
    check(!reqReady, "R12 busy not ready", reqReady, 0);
    waitDone("R12 read done");
    check(nAddr == 1 && aCbe[0] == 4'b0110 && aAd[0] == 32'h4000, "R2 read address phase", {aCbe[0], aAd[0][27:0]}, {4'b0110, 28'h4000});
    check(nRd == 3, "R2 read word count", nRd, 3);
    for (int i = 0; i < 3; i++) check(rdLog[i] == rdPat(i), "R2 read data", rdLog[i], rdPat(i));
    check(xferFrame == 2 && cbeBad == 0, "R2 frame on final phase, cbe 0000", xferFrame, 2);
    check(reqRiseCyc == aCyc[0], "R5 read request drop", reqRiseCyc, aCyc[0]);
    check(holdBad == 0 && irdyBad == 0, "R8 irdy timing and hold", holdBad + irdyBad, 0);
    check(parBad == 0 && nPar >= 1, "R9 address parity", parBad, 0);
    check(nErr == 0 && nDone == 1 && nParErr == 0, "R12 R10 clean read end", {nErr[7:0], nDone[7:0], nParErr[7:0]}, 24'h000100);
  endtask

  task automatic testWrites(input bit keep);
    clearLog(); devLat = 1; waitSt = keep ? 0 : 1; keepBusReq = keep;
    wdata[0] = 32'h1111_2222; wbe[0] = 4'b1111;
    wdata[1] = 32'h3333_4444; wbe[1] = 4'b0011;
    wdata[2] = 32'h5555_6666; wbe[2] = 4'b1100;
    wdata[3] = 32'h7777_8888; wbe[3] = 4'b0101;
    issue(1, 32'h0001_0010, 3);
    waitDone("R12 write done");
    check(nAddr == 3 && nWr == 3 && wrIdx == 3, "R3 three transactions", nAddr, 3);
    for (int k = 0; k < 3; k++) begin
      check(aAd[k] == 32'h0001_0010 + 32'(4 * k) && aCbe[k] == 4'b0111, "R3 write address/command", aAd[k], 32'h0001_0010 + 32'(4 * k));
      check(wrAd[k] == wdata[k] && wrCbe[k] == ~wbe[k], "R3 write data/byte enables", {wrCbe[k], wrAd[k][27:0]}, {~wbe[k], wdata[k][27:0]});
      check(aGap[k], "R4 idle clock before frame", aGap[k], 1);
    end
    check(xferFrame == 0, "R3 single data phase", xferFrame, 0);
    check(!aReq[0] && !aReq[1], "R4 request held between writes", {aReq[0], aReq[1]}, 0);
    if (keep) begin
      check(!aReq[2] && reqRiseCyc == lastXferCyc, "R6 held request drop", reqRiseCyc, lastXferCyc);
    end else begin
      check(aReq[2] && reqRiseCyc == aCyc[2], "R5 early request drop", reqRiseCyc, aCyc[2]);
    end
    check(holdBad == 0 && irdyBad == 0, "R8 write hold", holdBad + irdyBad, 0);
    check(parBad == 0 && nPar >= 6, "R9 write parity", parBad, 0);
  endtask

  task automatic testGrant();
    int rel;
    clearLog(); devLat = 1; waitSt = 0; keepBusReq = 0;
    pciGntN = 1; otherFrameN = 0;
    issue(0, 32'h0000_0800, 1);
    repeat (4) stepc();
    check(nAddr == 0 && !pciReqN, "R7 waits for grant", nAddr, 0);
    pciGntN = 0;
    repeat (3) stepc();
    check(nAddr == 0, "R7 waits for idle bus", nAddr, 0);
    otherFrameN = 1; rel = ncyc;
    waitDone("R12 delayed read done");
    check(nAddr == 1 && aCyc[0] == rel + 1, "R7 start after idle", aCyc[0], rel + 1);
  endtask

  task automatic testDevselEdge();
    clearLog(); devLat = 4; waitSt = 0;
    issue(0, 32'h0000_0900, 1);
    waitDone("R12 late claim done");
    check(nErr == 0 && nRd == 1, "R11 fourth-edge claim completes", {nErr[7:0], nRd[7:0]}, 16'h0001);
  endtask

  task automatic testAbort();
    clearLog(); devLat = 99; waitSt = 0;
    issue(0, 32'h0000_0A00, 2);
    waitDone("R12 abort done");
    check(nErr == 1 && nDone == 1 && nRd == 0, "R11 abort reported", {nErr[7:0], nRd[7:0]}, 16'h0100);
    check(frameRiseCyc == aCyc[0] + 5, "R11 frame released", frameRiseCyc, aCyc[0] + 5);
    check(irdyRiseCyc == aCyc[0] + 6, "R11 irdy released after frame", irdyRiseCyc, aCyc[0] + 6);
    check(pciReqN && reqReady, "R12 idle after abort", {pciReqN, reqReady}, 2'b11);
  endtask

  task automatic testParity();
    clearLog(); devLat = 1; waitSt = 0; badIdx = 1;
    issue(0, 32'h0000_0C00, 2);
    waitDone("R12 parity read done");
    check(nRd == 2 && nParErr == 1, "R10 one parity error", nParErr, 1);
    badIdx = -1;
  endtask

  initial begin
    clearLog();
    repeat (3) stepc();
    rstN = 1'b1;
    stepc();
    testReset();
    testReadBurst();
    testWrites(0);
    testWrites(1);
    testGrant();
    testDevselEdge();
    testAbort();
    testParity();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule